// File: doc/BRIEF.md
# Compare-Match Timer with Sticky Status Flags

This block is an up-counter with two compare registers. It raises three sticky status flags: one for a match on compare A, one for a match on compare B, and one for counter wrap-around. The counter advances by one on every clock cycle in which an external count strobe is high. The counter can also be loaded directly over a small register bus, which gives software access to the counter, both compare values and a combined control/status register.

A match on compare B can act on a single output pin. A two-bit mode field chooses whether the pin is left alone, forced low, forced high or inverted. A match on compare A can send a one-cycle start pulse to an external converter, gated by an enable bit. Software cannot set a flag. It can clear a flag only with a two-step handshake: first it reads the status register while that flag is 1, then it writes 0 to that flag's bit. This handshake stops software from clearing an event it has not yet seen.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, both compare registers, the control/status register, the output pin, the start pulse and the read data are all 0.
- R2: In each cycle with `cnt_en` high, the counter (bus address 1) goes up by one and wraps from 0xFF to 0x00. With `cnt_en` low it holds its value.
- R3: Compare register A (address 2) and compare register B (address 3) are written and read back over the bus.
- R4: The wrap flag (status bit 5) becomes 1 when the counter steps from 0xFF to 0x00.
- R5: The match-A flag (status bit 6) and the match-B flag (status bit 7) become 1 when the counter value just after an increment equals compare A or compare B.
- R6: A flag clears only when a status read sees it at 1 and a later status write puts 0 in its bit. A zero write with no such read leaves the flag at 1. Any status write uses up all pending read qualifications.
- R7: Each flag is qualified for clearing separately. A read that saw only one flag at 1 lets the next zero write clear that flag alone.
- R8: Writing 1 to a flag bit never sets it.
- R9: If a flag's event happens in the same cycle as a write that would clear it, the flag stays at 1.
- R10: When the trigger enable (status bit 4) is 1, every match-A event produces a `conv_start` pulse exactly one cycle long. When the enable is 0, no pulse appears.
- R11: The output mode (status bits 3:2) acts on a match-B event as follows: 00 keeps the pin, 01 drives it to 0, 10 drives it to 1, 11 inverts it. The pin changes only on a match-B event.
- R12: A bus write to the counter overrides any increment in the same cycle and raises no match or wrap event. Status bits 4:2 read back as written, and bits 1:0 read as 0.
- R13: Read data shows up on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count strobe; the counter steps once per cycle while it is high |
| bus_addr | input | 2 | Register select: 0 status/control, 1 counter, 2 compare A, 3 compare B |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| cmp_out | output | 1 | Pin driven by compare-match B |
| conv_start | output | 1 | One-cycle converter start request |

## Verification
If a flag's read qualification is lost or leaks to another flag, the fault shows at the ports on the first status read after the next zero write: a flag is still set when it should be gone, or gone when it should still be set. A wrong counter or compare value shows within one cycle, because `conv_start` or `cmp_out` moves at the wrong step, and it also shows on the next counter read-back. A mode decode error changes the pin on the very cycle of the compare-B match. For that reason every mode is driven through a match while the starting pin level is known.

// File: rtl/ct_pkg.sv
// Shared definitions for the compare-match timer: register map,
// output modes and status-register bit positions.
package ct_pkg;
    localparam int unsigned REG_AW   = 2;
    localparam int unsigned CSR_W    = 8;
    localparam int unsigned FLAG_N   = 3;
    // flag index 0 wrap, 1 match A, 2 match B; mapped to status bits 5..7
    localparam int unsigned FLAG_LSB = 5;
    localparam int unsigned TE_BIT   = 4;
    localparam int unsigned MODE_LSB = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_CSR  = 2'd0,
        RA_CNT  = 2'd1,
        RA_CMPA = 2'd2,
        RA_CMPB = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_LOW  = 2'd1,
        PIN_HIGH = 2'd2,
        PIN_FLIP = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/ct_counter.sv
// Up-counter with load and two equality comparators.
// Assumes: a load beats an increment in the same cycle, and a load
// raises no events. Matches are taken on the post-increment value.
module ct_counter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    output logic [DW-1:0] count_q,
    output logic          hit_a,
    output logic          hit_b,
    output logic          wrap
);
    localparam logic [DW-1:0] TOP = '1;

    logic [DW-1:0] nxt;
    logic          step;

    // next value and event decode for this cycle
    always_comb begin
        step  = inc & ~load;
        nxt   = count_q + DW'(1);
        hit_a = step & (nxt == cmp_a);
        hit_b = step & (nxt == cmp_b);
        wrap  = step & (count_q == TOP);
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (load)  count_q <= load_val;
        else if (step)  count_q <= nxt;
    end
endmodule

// File: rtl/ct_flag.sv
// One sticky status flag with its own read qualification.
// Assumes: rd_hit/wr_hit mark status-register accesses; a set event
// wins over a clearing write in the same cycle.
module ct_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag_q
);
    logic arm_q;
    logic clr;

    // a qualified zero write clears
    always_comb clr = wr_hit & arm_q & ~wr_bit;

    // read qualification: armed by a read seeing 1, dropped by any status write
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= 1'b0;
        else if (wr_hit) arm_q <= 1'b0;
        else             arm_q <= arm_q | (rd_hit & flag_q);
    end

    // flag state, event over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_evt | (flag_q & ~clr);
    end
endmodule

// File: rtl/ct_pin.sv
// Output pin acted on by compare-match B according to a 2-bit mode.
// Assumes: the pin resets low and moves only on a hit.
module ct_pin
    import ct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  pin_mode_e mode,
    output logic      pin_q
);
    // pin update on a match
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else if (hit) begin
            case (mode)
                PIN_LOW:  pin_q <= 1'b0;
                PIN_HIGH: pin_q <= 1'b1;
                PIN_FLIP: pin_q <= ~pin_q;
                default:  pin_q <= pin_q;
            endcase
        end
    end
endmodule

// File: rtl/cmp_timer.sv
// Compare-match timer top: register bus, control bits, three sticky
// flags, converter start pulse and compare-B output pin.
// Assumes: DW >= 8 (the status register occupies the low 8 bits);
// read data is registered with one cycle of latency.
module cmp_timer
    import ct_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              cmp_out,
    output logic              conv_start
);
    reg_addr_e         addr_e;
    logic              wr_csr, rd_csr, wr_cnt;
    logic [DW-1:0]     cnt_q, cmpa_q, cmpb_q, csr_val;
    logic              hit_a, hit_b, wrap_evt;
    logic [FLAG_N-1:0] evt, flag_q;
    logic              te_q;
    pin_mode_e         mode_q;

    // bus access decode
    always_comb begin
        addr_e = reg_addr_e'(bus_addr);
        wr_csr = bus_wr & (addr_e == RA_CSR);
        rd_csr = bus_rd & (addr_e == RA_CSR);
        wr_cnt = bus_wr & (addr_e == RA_CNT);
        evt    = {hit_b, hit_a, wrap_evt};
    end

    ct_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_en),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .cmp_a    (cmpa_q),
        .cmp_b    (cmpb_q),
        .count_q  (cnt_q),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .wrap     (wrap_evt)
    );

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        ct_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt[i]),
            .rd_hit  (rd_csr),
            .wr_hit  (wr_csr),
            .wr_bit  (bus_wdata[FLAG_LSB+i]),
            .flag_q  (flag_q[i])
        );
    end

    ct_pin u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_b),
        .mode  (mode_q),
        .pin_q (cmp_out)
    );

    // compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else if (bus_wr) begin
            if (addr_e == RA_CMPA) cmpa_q <= bus_wdata;
            if (addr_e == RA_CMPB) cmpb_q <= bus_wdata;
        end
    end

    // control bits: trigger enable and pin mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q   <= 1'b0;
            mode_q <= PIN_KEEP;
        end else if (wr_csr) begin
            te_q   <= bus_wdata[TE_BIT];
            mode_q <= pin_mode_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
        end
    end

    // converter start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= hit_a & te_q;
    end

    // status/control read image
    always_comb begin
        csr_val = '0;
        csr_val[FLAG_LSB+FLAG_N-1:FLAG_LSB] = flag_q;
        csr_val[TE_BIT] = te_q;
        csr_val[MODE_LSB+1:MODE_LSB] = mode_q;
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            case (addr_e)
                RA_CSR:  bus_rdata <= csr_val;
                RA_CNT:  bus_rdata <= cnt_q;
                RA_CMPA: bus_rdata <= cmpa_q;
                default: bus_rdata <= cmpb_q;
            endcase
        end
    end
endmodule

// File: rtl/ct_timer_chk.sv
// Property checker for cmp_timer, attached by bind below.
module ct_timer_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] count,
    input logic          hit_a,
    input logic          hit_b,
    input logic          wrap,
    input logic [2:0]    flags,
    input logic          cmp_out,
    input logic          conv_start
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !(bus_wr && bus_addr == 2'd1)) |=> (count == DW'($past(count) + DW'(1))));
    // R12
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (count == $past(bus_wdata)));
    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(wrap));
    // R5
    cma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(hit_a));
    // R5
    cmb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(hit_b));
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags) != 3'b000) |-> $past(bus_wr && bus_addr == 2'd0));
    // R10
    conv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(hit_a));
    // R10
    conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R11
    pin_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_out) |-> $past(hit_b));
endmodule

bind cmp_timer ct_timer_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count      (cnt_q),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .wrap       (wrap_evt),
    .flags      (flag_q),
    .cmp_out    (cmp_out),
    .conv_start (conv_start)
);

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_out, conv_start;

    always #2 clk = ~clk;

    cmp_timer #(.DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_out(cmp_out), .conv_start(conv_start)
    );

    typedef struct {
        logic [7:0] rd;
        logic       pin;
        logic       pulse;
        string      tag;
    } exp_t;
    exp_t q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // requirement-level model state
    logic [7:0] m_cnt = 0, m_ca = 0, m_cb = 0, m_rdata = 0;
    logic [2:0] m_flag = 0, m_arm = 0;   // [2] match B, [1] match A, [0] wrap
    logic       m_te = 0, m_pin = 0;
    logic [1:0] m_mode = 0;

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_reg(logic [1:0] a);
        case (a)
            2'd0:    return {m_flag, m_te, m_mode, 2'b00};
            2'd1:    return m_cnt;
            2'd2:    return m_ca;
            default: return m_cb;
        endcase
    endfunction

    // driver: one bus/count cycle, expected result queued
    task automatic cyc(bit en, bit rd, bit wr, logic [1:0] a, logic [7:0] wd, string tag);
        logic       ea, eb, ov, pulse;
        logic [2:0] clr;
        logic [7:0] nc;
        exp_t       e;
        @(negedge clk);
        cnt_en = en; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        ea = 0; eb = 0; ov = 0; clr = 0;
        if (rd) m_rdata = m_reg(a);
        if (wr && a == 2'd1) m_cnt = wd;
        else if (en) begin
            nc = m_cnt + 8'd1;
            ov = (m_cnt == 8'hFF);
            ea = (nc == m_ca);
            eb = (nc == m_cb);
            m_cnt = nc;
        end
        pulse = ea & m_te;
        if (eb) begin
            case (m_mode)
                2'd1: m_pin = 1'b0;
                2'd2: m_pin = 1'b1;
                2'd3: m_pin = ~m_pin;
                default: ;
            endcase
        end
        if (wr && a == 2'd0) begin
            clr = m_arm & ~wd[7:5];
            m_arm = 3'b000;
            m_te = wd[4];
            m_mode = wd[3:2];
        end else if (rd && a == 2'd0) m_arm = m_arm | m_flag;
        m_flag = {eb, ea, ov} | (m_flag & ~clr);
        if (wr && a == 2'd2) m_ca = wd;
        if (wr && a == 2'd3) m_cb = wd;
        e.rd = m_rdata; e.pin = m_pin; e.pulse = pulse; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, string tag); cyc(0, 0, 1, a, d, tag); endtask
    task automatic rd(logic [1:0] a, string tag); cyc(0, 1, 0, a, 8'd0, tag); endtask
    task automatic inc(string tag); cyc(1, 0, 0, 2'd0, 8'd0, tag); endtask

    // monitor: compare after each active edge
    initial forever begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "rdata", bus_rdata, e.rd);
            chk(e.tag, "cmp_out", {7'd0, cmp_out}, {7'd0, e.pin});
            chk(e.tag, "conv_start", {7'd0, conv_start}, {7'd0, e.pulse});
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rdata in reset", bus_rdata, 8'd0);
        chk("R1", "pin in reset", {7'd0, cmp_out}, 8'd0);
        chk("R1", "pulse in reset", {7'd0, conv_start}, 8'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rd(2'(i), "R1");
        // compare registers
        wr(2'd2, 8'd3, "R3"); wr(2'd3, 8'd5, "R3");
        rd(2'd2, "R3"); rd(2'd3, "R3");
        // control readback, low bits read zero
        wr(2'd0, 8'h1F, "R12"); rd(2'd0, "R12");
        // count to A then B
        inc("R2"); inc("R2"); inc("R5"); inc("R10"); inc("R11");
        rd(2'd1, "R2");
        cyc(0, 0, 0, 2'd0, 8'd0, "R13"); cyc(0, 0, 0, 2'd0, 8'd0, "R13");
        rd(2'd1, "R2");
        // zero write without prior read keeps flags
        wr(2'd0, 8'h1C, "R6"); rd(2'd0, "R6");
        wr(2'd0, 8'h1C, "R6"); rd(2'd0, "R6");
        // ones cannot set flags
        wr(2'd0, 8'hFC, "R8"); rd(2'd0, "R8");
        // load has no events
        wr(2'd1, 8'd3, "R12"); rd(2'd0, "R12"); rd(2'd1, "R12");
        // per-flag qualification
        inc("R7"); inc("R7"); rd(2'd0, "R7");
        wr(2'd1, 8'd2, "R7"); inc("R7");
        wr(2'd0, 8'h1C, "R7"); rd(2'd0, "R7");
        // set beats clear
        rd(2'd0, "R9"); wr(2'd1, 8'd2, "R9");
        cyc(1, 0, 1, 2'd0, 8'h1C, "R9"); rd(2'd0, "R9");
        rd(2'd0, "R9"); wr(2'd0, 8'h1C, "R9"); rd(2'd0, "R9");
        // wrap
        wr(2'd1, 8'hFE, "R4"); inc("R4"); rd(2'd0, "R4");
        inc("R4"); rd(2'd0, "R4"); rd(2'd1, "R2");
        // trigger disabled
        wr(2'd0, 8'h00, "R10"); wr(2'd1, 8'd2, "R10"); inc("R10"); rd(2'd0, "R10");
        // output modes
        wr(2'd0, 8'h04, "R11"); wr(2'd1, 8'd4, "R11"); inc("R11");
        wr(2'd0, 8'h08, "R11"); wr(2'd1, 8'd4, "R11"); inc("R11");
        wr(2'd1, 8'd9, "R11"); inc("R11");
        wr(2'd0, 8'h00, "R11"); wr(2'd1, 8'd4, "R11"); inc("R11");
        wr(2'd0, 8'h0C, "R11"); wr(2'd1, 8'd4, "R11"); inc("R11");
        wr(2'd1, 8'd4, "R11"); inc("R11");
        rd(2'd0, "R11");
        cyc(0, 0, 0, 2'd0, 8'd0, "R13");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule